// File: doc/BRIEF.md
# Object Overlap Collision Register

This block watches a stream of pixel words. Each word is a bit vector with one bit for each display object class drawn at that pixel. Seven classes are tracked, on bit positions 0 to 5 and 7. Bit 6 is carried on the bus but never tracked. Whenever one accepted pixel shows two or more tracked classes, each of those classes records every other class present. The records form a table with one entry per class. Each entry is a bitmask of the classes that class has overlapped since the last read.

A processor queries the table through a one-cycle read strobe. A selection register chooses which classes the query covers. The processor writes that register through its own strobe, and the value persists across reads. The answer is the OR of every class that overlapped any selected class, with each selected class's own bit removed from its own contribution. The read also clears the whole table. The pixel input uses valid/ready. The block never applies back-pressure: `pix_ready` is high whenever reset is released, and every word presented with `pix_valid` high is consumed on that clock edge. The read and selection strobes are plain pulses without a handshake.

Top module: `collision_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_valid` and `rd_data` are 0. The selection register and every table entry start at 0.
- R2: `pix_ready` is 1 whenever reset is released, and a word is accepted on every rising edge where `pix_valid` is 1.
- R3: An accepted pixel whose tracked bits (mask 0xBF) number two or more ORs that tracked vector into the entry of each class present. A pixel with zero or one tracked bit changes nothing, and bit 6 of `pix_objs` is ignored.
- R4: A read strobe on a rising edge makes `rd_valid` 1 for exactly the following cycle, with the result on `rd_data`. Outside that cycle `rd_data` is 0.
- R5: The result is the OR, over each set selection bit m and each tracked class c whose entry has bit m set, of that entry with bit m cleared.
- R6: Bit 6 of `rd_data` is always 0. Bit 6 of the selection register adds nothing to any result.
- R7: Every read clears all table entries, so a following read with no pixels in between returns 0.
- R8: A pixel accepted on the same edge as a read is left out of that read's result and is present in the table after the clear.
- R9: A selection write takes effect from the next edge and persists across reads. A read on the same edge as a write uses the previous selection.
- R10: A read with the selection at 0 returns 0 and still clears the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel word present |
| pix_ready | output | 1 | Pixel word accepted (always high out of reset) |
| pix_objs | input | 8 | Object classes drawn at this pixel |
| sel_we | input | 1 | Selection register write strobe |
| sel_wdata | input | 8 | New selection mask |
| rd_en | input | 1 | Read strobe: query and clear |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_data | output | 8 | Read result |

## Verification
Several properties are checked on every cycle:
- the one-cycle read latency and the single-cycle width of `rd_valid`;
- `rd_data` being 0 outside a result cycle;
- bit 6 of the result always being 0;
- a read under a zero selection returning 0;
- two back-to-back reads with no pixel at the first read giving 0 on the second.

Only the bench's scenarios can show that the partner classes reported are correct, since that needs the history of pixel words. The same holds for pixels arriving on the same edge as a clearing read, and for a selection write coinciding with a read. The bench covers these with a reference model that follows every pixel, write and read.

// File: rtl/coll_pkg.sv
package coll_pkg;
  localparam int unsigned OBJ_W = 8;
  localparam logic [OBJ_W-1:0] TRACK_DEFAULT = 8'hBF;

  typedef logic [OBJ_W-1:0] obj_vec_t;

  // true when at least two bits of v are set
  function automatic logic multi_hit(input obj_vec_t v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < OBJ_W; i++) n += v[i];
    return n >= 2;
  endfunction
endpackage

// File: rtl/coll_sel_reg.sv
module coll_sel_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (we) sel_q <= wdata;
  end
endmodule

// File: rtl/coll_table.sv
module coll_table #(
  parameter int unsigned   W     = 8,
  parameter logic [W-1:0]  TRACK = 8'hBF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_fire,
  input  logic [W-1:0] pix_objs,
  input  logic         clr,
  output logic [W-1:0] entries [W]
);
  import coll_pkg::*;

  logic [W-1:0] act;
  logic         hit;

  always_comb begin
    act = pix_objs & TRACK;
    hit = pix_fire && multi_hit(act);
  end

  for (genvar c = 0; c < W; c++) begin : g_entry
    if (TRACK[c]) begin : g_trk
      logic [W-1:0] nxt;
      always_comb begin
        nxt = clr ? '0 : entries[c];
        if (hit && act[c]) nxt = nxt | act;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) entries[c] <= '0;
        else entries[c] <= nxt;
      end
    end else begin : g_none
      assign entries[c] = '0;
    end
  end
endmodule

// File: rtl/coll_query.sv
module coll_query #(
  parameter int unsigned   W     = 8,
  parameter logic [W-1:0]  TRACK = 8'hBF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] entries [W],
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] part [W];
  logic [W-1:0] result;

  // one partial result per selection bit
  for (genvar m = 0; m < W; m++) begin : g_sel
    always_comb begin
      part[m] = '0;
      if (sel[m]) begin
        for (int c = 0; c < W; c++) begin
          if (TRACK[c] && entries[c][m])
            part[m] = part[m] | (entries[c] & ~(W'(1) << m));
        end
      end
    end
  end

  always_comb begin
    result = '0;
    for (int m = 0; m < W; m++) result = result | part[m];
    result = result & TRACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? result : '0;
    end
  end
endmodule

// File: rtl/collision_reg.sv
module collision_reg #(
  parameter int unsigned   W          = coll_pkg::OBJ_W,
  parameter logic [W-1:0]  TRACK_MASK = coll_pkg::TRACK_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_valid,
  output logic         pix_ready,
  input  logic [W-1:0] pix_objs,
  input  logic         sel_we,
  input  logic [W-1:0] sel_wdata,
  input  logic         rd_en,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] sel_q;
  logic [W-1:0] entries [W];
  logic         pix_fire;

  assign pix_ready = rst_n;
  assign pix_fire  = pix_valid && pix_ready;

  coll_sel_reg #(.W(W)) sel_i (
    .clk(clk), .rst_n(rst_n), .we(sel_we), .wdata(sel_wdata), .sel_q(sel_q)
  );

  coll_table #(.W(W), .TRACK(TRACK_MASK)) tbl_i (
    .clk(clk), .rst_n(rst_n), .pix_fire(pix_fire), .pix_objs(pix_objs),
    .clr(rd_en), .entries(entries)
  );

  coll_query #(.W(W), .TRACK(TRACK_MASK)) qry_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel_q), .entries(entries),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/collision_reg_chk.sv
module collision_reg_chk #(
  parameter int unsigned   W     = 8,
  parameter logic [W-1:0]  TRACK = 8'hBF
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pix_valid,
  input logic         rd_en,
  input logic         rd_valid,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] sel_q
);
  // R4
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R4
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == '0);

  // R6
  untracked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~TRACK) == '0);

  // R10
  empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && sel_q == '0 |=> rd_data == '0);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !pix_valid ##1 rd_en |=> rd_data == '0);
endmodule

bind collision_reg collision_reg_chk #(.W(W), .TRACK(TRACK_MASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .rd_en(rd_en),
  .rd_valid(rd_valid), .rd_data(rd_data), .sel_q(sel_q)
);

// File: tb/collision_reg_tb.sv
module collision_reg_tb_top;
  localparam logic [7:0] TRK = 8'hBF;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       pix_valid = 0;
  logic       pix_ready;
  logic [7:0] pix_objs = '0;
  logic       sel_we = 0;
  logic [7:0] sel_wdata = '0;
  logic       rd_en = 0;
  logic       rd_valid;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  int m_ent [8];
  int m_sel = 0;
  int exp_valid = 0;
  int exp_data = 0;

  always #5 clk = ~clk;

  collision_reg dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_objs(pix_objs), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) m_ent[c] = 0;
      m_sel = 0; exp_valid = 0; exp_data = 0;
    end else begin
      int v, r, n;
      if (rd_en) begin
        r = 0;
        for (int m = 0; m < 8; m++)
          for (int c = 0; c < 8; c++)
            if (TRK[c] && m_sel[m] && m_ent[c][m]) r = r | (m_ent[c] & ~(1 << m));
        exp_data = r & 'hBF; exp_valid = 1;
        for (int c = 0; c < 8; c++) m_ent[c] = 0;
      end else begin
        exp_valid = 0; exp_data = 0;
      end
      if (sel_we) m_sel = sel_wdata;
      if (pix_valid) begin
        v = pix_objs & 'hBF;
        n = $countones(v);
        if (n >= 2) for (int c = 0; c < 8; c++) if (v[c]) m_ent[c] = m_ent[c] | v;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, rd_valid, exp_valid, "rd_valid");
      check(cur_req, rd_data, exp_data, "rd_data");
      check("R2", pix_ready, 1, "pix_ready");
    end
  end

  task automatic step(input bit pv, input logic [7:0] po, input bit we,
                      input logic [7:0] wd, input bit rd);
    pix_valid = pv; pix_objs = po; sel_we = we; sel_wdata = wd; rd_en = rd;
    @(posedge clk); #1;
    pix_valid = 0; sel_we = 0; rd_en = 0;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0); endtask
  task automatic pix(input logic [7:0] p); step(1, p, 0, 0, 0); endtask
  task automatic wsel(input logic [7:0] s); step(0, 0, 1, s, 0); endtask
  task automatic rd(); step(0, 0, 0, 0, 1); idle(); endtask

  initial begin
    #2;
    check("R1", rd_valid, 0, "rd_valid in reset");
    check("R1", rd_data, 0, "rd_data in reset");
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", rd_valid, 0, "rd_valid after reset");
    @(posedge clk); #1;
    // R1: empty table and zero selection
    cur_req = "R1"; wsel(8'hFF); rd();
    cur_req = "R9"; wsel(8'h03); rd();
    cur_req = "R3"; pix(8'h03); rd();
    cur_req = "R6"; wsel(8'hFF); pix(8'h04); pix(8'h44); pix(8'h40); rd();
    cur_req = "R5"; wsel(8'h01); pix(8'h81); pix(8'h0C); rd();
    cur_req = "R5"; wsel(8'h0F); pix(8'h09); pix(8'h06); pix(8'h30); rd();
    cur_req = "R7"; rd();
    cur_req = "R8"; wsel(8'h10); pix(8'h11); step(1, 8'h30, 0, 0, 1); idle(); rd();
    cur_req = "R10"; wsel(8'h00); pix(8'h03); rd(); wsel(8'h01); rd();
    cur_req = "R9"; pix(8'h06); pix(8'h03); step(0, 0, 1, 8'h02, 1); idle();
    pix(8'h03); rd(); rd();
    cur_req = "R4"; pix(8'h81); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); idle();
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] p;
      p = 8'($urandom);
      step($urandom_range(0, 3) != 0, p, $urandom_range(0, 9) == 0, 8'($urandom),
           $urandom_range(0, 5) == 0);
    end
    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule